// File: doc/BRIEF.md
# Multiplexed Error-Flag Port Controller

This block stores the error flags of a video error-detection checker and makes them available to an external controller over a narrow five-bit port. Three groups of five flags are kept: full-field, active-picture and ancillary. Each group is kept twice, once for the incoming packet and once for the outgoing packet. Beside them sit two validity bits, which always belong to the incoming packet, a checksum-error flag, a status bit and a stored in/out bit. The in/out bit decides which packet copy a port access reaches.

A single strobe sets the direction of the port. While it is high, the controller reads one group at a time, chosen by a 2-bit select, and the block drives the bus. While it is low, the controller writes into the selected group. The turnaround is exact to the cycle. On the first low cycle the block only lets go of the bus. Reads deliver the chosen group one clock after the select is sampled.

The checker loads new results through a strobe-qualified update input. A CRC-mode input keeps the checker from overwriting the stored error flags, so that only port writes change them. The pad is outside the block: the bus appears as separate input, output and output-enable signals.

Top module: `flag_port_ctrl`

## Requirements
- R1: Synchronous reset clears all error flags, validity, checksum and status bits. It sets the in/out bit to incoming (1), puts the port in read mode with select 00, and makes a read of any group return 00000.
- R2: `bus_oe` is high in the cycle after a rising clock edge that samples `rd_wr` high, and low in the cycle after an edge that samples it low.
- R3: A read with select 00, 01 or 10 returns the full-field, active-picture or ancillary group respectively. Bits 4..0 are UES, IDA, IDH, EDA, EDH. The flags come from the incoming copy when the in/out bit is 1 and from the outgoing copy when it is 0. In the flag vectors, group g occupies bits [5g+4:5g].
- R4: A read with select 11 returns these bits:
  - bit 4: the checksum-error flag when in/out is 0, and 0 when in/out is 1
  - bit 3: the active-picture validity bit
  - bit 2: the full-field validity bit
  - bit 1: the status bit
  - bit 0: always 0
- R5: The select sampled at one read edge is reflected on `bus_out` after the next edge, a one-clock latency.
- R6: The first edge that samples `rd_wr` low after read mode writes nothing.
- R7: Each later edge with `rd_wr` low and select 00..10 replaces only the selected group, and only in the copy chosen by the in/out bit. The other groups, the other copy and all control bits are left unchanged.
- R8: A write with select 11 loads bus bit 3 into active-picture validity, bit 2 into full-field validity and bit 0 into the in/out bit. Bus bits 4 and 1 are ignored.
- R9: When `chk_upd` is high, the checksum, status and validity bits are loaded from the checker. With CRC mode off, both error-flag copies are loaded as well. A port write in the same cycle takes precedence for the items it writes.
- R10: While `crc_mode` is high, `chk_upd` leaves both error-flag copies unchanged, while the checksum, status and validity bits still load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_wr | input | 1 | Port direction: 1 read, 0 write |
| grp_sel | input | 2 | Group select |
| bus_in | input | 5 | Data from the external controller |
| bus_out | output | 5 | Read data to the pad |
| bus_oe | output | 1 | Pad output enable |
| crc_mode | input | 1 | Block checker updates of error flags |
| chk_upd | input | 1 | Checker result strobe |
| chk_in_err | input | 15 | Checker flags, incoming packet |
| chk_out_err | input | 15 | Checker flags, outgoing packet |
| chk_apv | input | 1 | Checker active-picture validity |
| chk_ffv | input | 1 | Checker full-field validity |
| chk_cksum | input | 1 | Checker checksum-error flag |
| chk_status | input | 1 | Checker status bit |

## Verification
Directed phases come first. They cover a bare read after reset, a write burst whose first beat must be dropped, and control writes that flip the in/out bit so the same select reaches the other copy. Checker loads are then applied with CRC mode on and off, which separates the flags that the mode blocks from those it does not. A long random phase follows. It mixes strobe runs of varied length, random selects, data, checker strobes and mode changes, which exercises turnarounds, write-versus-checker collisions and masking of the checksum bit against the in/out setting.

// File: rtl/flag_port_ctrl.sv
module flag_port_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_wr,
  input  logic [1:0]  grp_sel,
  input  logic [4:0]  bus_in,
  output logic [4:0]  bus_out,
  output logic        bus_oe,
  input  logic        crc_mode,
  input  logic        chk_upd,
  input  logic [14:0] chk_in_err,
  input  logic [14:0] chk_out_err,
  input  logic        chk_apv,
  input  logic        chk_ffv,
  input  logic        chk_cksum,
  input  logic        chk_status
);
  localparam int GW = 5;
  localparam int NG = 3;
  localparam int FW = GW * NG;

  logic          rd_q, apv_q, ffv_q, ck_q, st_q, io_q;
  logic [1:0]    sel_q;
  logic [GW-1:0] dout_q;
  logic [FW-1:0] err_in_q, err_out_q;

  logic          wr_en, wr_grp, wr_ctl, chk_err_ld;
  logic [FW-1:0] grp_mask, wr_data, in_base, out_base, err_in_d, err_out_d, err_rd;
  logic [GW-1:0] rd_mux;

  assign wr_en      = !rd_wr && !rd_q;
  assign wr_grp     = wr_en && (grp_sel != 2'b11);
  assign wr_ctl     = wr_en && (grp_sel == 2'b11);
  assign chk_err_ld = chk_upd && !crc_mode;
  assign wr_data    = {NG{bus_in}};

  for (genvar g = 0; g < NG; g++) begin : g_mask
    assign grp_mask[g*GW +: GW] = {GW{grp_sel == 2'(g)}};
  end

  assign in_base   = chk_err_ld ? chk_in_err  : err_in_q;
  assign out_base  = chk_err_ld ? chk_out_err : err_out_q;
  assign err_in_d  = (wr_grp &&  io_q) ? ((in_base  & ~grp_mask) | (wr_data & grp_mask)) : in_base;
  assign err_out_d = (wr_grp && !io_q) ? ((out_base & ~grp_mask) | (wr_data & grp_mask)) : out_base;

  assign err_rd = io_q ? err_in_q : err_out_q;
  always_comb begin
    rd_mux = {ck_q & ~io_q, apv_q, ffv_q, st_q, 1'b0};
    for (int g = 0; g < NG; g++)
      if (sel_q == 2'(g)) rd_mux = err_rd[g*GW +: GW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b1;
      sel_q     <= 2'b00;
      dout_q    <= '0;
      err_in_q  <= '0;
      err_out_q <= '0;
      apv_q     <= 1'b0;
      ffv_q     <= 1'b0;
      ck_q      <= 1'b0;
      st_q      <= 1'b0;
      io_q      <= 1'b1;
    end else begin
      rd_q      <= rd_wr;
      sel_q     <= grp_sel;
      dout_q    <= rd_mux;
      err_in_q  <= err_in_d;
      err_out_q <= err_out_d;
      if (chk_upd) begin
        ck_q  <= chk_cksum;
        st_q  <= chk_status;
      end
      if (wr_ctl) begin
        apv_q <= bus_in[3];
        ffv_q <= bus_in[2];
        io_q  <= bus_in[0];
      end else if (chk_upd) begin
        apv_q <= chk_apv;
        ffv_q <= chk_ffv;
      end
    end
  end

  assign bus_out = dout_q;
  assign bus_oe  = rd_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (bus_oe && err_in_q == '0 && err_out_q == '0 && io_q));

  // R2
  drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_wr |=> bus_oe);

  // R2
  release_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_wr |=> !bus_oe);

  // R4
  ctl_bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_wr && bus_oe && grp_sel == 2'b11) |=> ##1 (bus_out[0] == 1'b0));

  // R6
  first_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_wr && bus_oe && !chk_upd) |=> ($stable(err_in_q) && $stable(err_out_q) && $stable(io_q) && $stable(apv_q)));

  // R7
  other_copy_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_wr && !bus_oe && io_q && !chk_upd) |=> $stable(err_out_q));

  // R10
  crc_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_mode && rd_wr) |=> ($stable(err_in_q) && $stable(err_out_q)));
endmodule

// File: tb/flag_port_ctrl_tb.sv
module flag_port_ctrl_tb;
  logic clk = 0, rst = 1, rd_wr = 1, crc_mode = 0, chk_upd = 0;
  logic chk_apv = 0, chk_ffv = 0, chk_cksum = 0, chk_status = 0;
  logic [1:0]  grp_sel = 0;
  logic [4:0]  bus_in = 0, bus_out;
  logic        bus_oe;
  logic [14:0] chk_in_err = 0, chk_out_err = 0;

  always #2 clk = ~clk;

  flag_port_ctrl u_dut (.clk, .rst, .rd_wr, .grp_sel, .bus_in, .bus_out, .bus_oe,
    .crc_mode, .chk_upd, .chk_in_err, .chk_out_err, .chk_apv, .chk_ffv,
    .chk_cksum, .chk_status);

  int checks = 0, failures = 0;
  logic [14:0] m_in, m_out;
  logic m_apv, m_ffv, m_ck, m_st, m_io, m_rd, m_rd_prev;
  logic [1:0] m_sel;
  logic [4:0] m_dout;

  function automatic logic [4:0] read_val(logic [1:0] s);
    logic [14:0] f = m_io ? m_in : m_out;
    case (s)
      2'b00:   return f[4:0];
      2'b01:   return f[9:5];
      2'b10:   return f[14:10];
      default: return {m_ck & ~m_io, m_apv, m_ffv, m_st, 1'b0};
    endcase
  endfunction

  function automatic logic [14:0] put_grp(logic [14:0] f, logic [1:0] s, logic [4:0] d);
    logic [14:0] r = f;
    r[s*5 +: 5] = d;
    return r;
  endfunction

  task automatic model_reset();
    m_in = 0; m_out = 0; m_apv = 0; m_ffv = 0; m_ck = 0; m_st = 0;
    m_io = 1; m_rd = 1; m_rd_prev = 1; m_sel = 0; m_dout = 0;
  endtask

  task automatic model_step();
    logic wr = !rd_wr && !m_rd;
    logic [14:0] ni = m_in, no = m_out;
    logic napv = m_apv, nffv = m_ffv, nio = m_io;
    m_dout = read_val(m_sel);
    if (chk_upd) begin
      if (!crc_mode) begin ni = chk_in_err; no = chk_out_err; end
      napv = chk_apv; nffv = chk_ffv; m_ck = chk_cksum; m_st = chk_status;
    end
    if (wr && grp_sel != 2'b11) begin
      if (m_io) ni = put_grp(ni, grp_sel, bus_in);
      else      no = put_grp(no, grp_sel, bus_in);
    end
    if (wr && grp_sel == 2'b11) begin
      napv = bus_in[3]; nffv = bus_in[2]; nio = bus_in[0];
    end
    m_in = ni; m_out = no; m_apv = napv; m_ffv = nffv; m_io = nio;
    m_rd_prev = m_rd; m_rd = rd_wr; m_sel = grp_sel;
  endtask

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic rw, logic [1:0] s, logic [4:0] b, string tag);
    rd_wr = rw; grp_sel = s; bus_in = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk_upd = 0;
    check("R2 bus_oe", {4'b0, bus_oe}, {4'b0, m_rd});
    if (m_rd && m_rd_prev) check(tag, bus_out, m_dout);
  endtask

  task automatic read_all(string tag);
    for (int s = 0; s < 4; s++) cyc(1, 2'(s), 5'h0, tag);
    cyc(1, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 oe after reset", {4'b0, bus_oe}, 5'd1);
    check("R1 data after reset", bus_out, 5'd0);
    read_all("R1 reset reads zero");

    // R6: first low beat dropped, R7 later beats land
    cyc(0, 2'b00, 5'h1F, "R6");
    cyc(0, 2'b01, 5'h15, "R7");
    cyc(0, 2'b10, 5'h0A, "R7");
    read_all("R6 R7 group writes, R3 R5 readback");
    // R8: control write, bits 4 and 1 ignored
    cyc(0, 2'b11, 5'h1F, "R8");
    cyc(0, 2'b11, 5'h1F, "R8");
    read_all("R8 control write incoming");
    cyc(0, 2'b11, 5'h00, "R8");
    cyc(0, 2'b11, 5'h1A, "R8");
    cyc(0, 2'b00, 5'h13, "R7");
    read_all("R8 R7 outgoing copy");

    // R10: crc mode blocks checker error flags
    crc_mode = 1; chk_in_err = 15'h7FFF; chk_out_err = 15'h5555;
    chk_apv = 1; chk_ffv = 0; chk_cksum = 1; chk_status = 1; chk_upd = 1;
    cyc(1, 0, 0, "R10");
    read_all("R10 flags held, R4 checksum shown");
    // R9: checker load with mode off, colliding with a port write
    crc_mode = 0; chk_upd = 1;
    cyc(1, 0, 0, "R9");
    read_all("R9 checker load");
    cyc(0, 2'b01, 0, "R9");
    chk_upd = 1; chk_out_err = 15'h2AAA;
    cyc(0, 2'b01, 5'h07, "R9 collision");
    read_all("R9 port write wins");

    for (int i = 0; i < 4000; i++) begin
      logic rw = ($urandom % 4 == 0) ? ~rd_wr : rd_wr;
      if ($urandom % 50 == 0) crc_mode = ~crc_mode;
      chk_upd = ($urandom % 8 == 0);
      chk_in_err = 15'($urandom); chk_out_err = 15'($urandom);
      {chk_apv, chk_ffv, chk_cksum, chk_status} = 4'($urandom);
      cyc(rw, 2'($urandom), 5'($urandom), "R3 R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule